// File: doc/BRIEF.md
# Paged Program Counter Unit

This block produces the fetch address for a word-addressed instruction store of 8K words, organised as four pages of 2K words. Each cycle it selects the next program counter value from one of several sources: plain sequential advance, an absolute branch (jump or subroutine call) that carries an 11-bit in-page target, a software write of the low address byte (a computed jump), a return from a subroutine or interrupt, or entry to the interrupt handler.

Branches and computed jumps do not carry the upper address bits themselves. Those bits come from a separate write-only page latch that software loads ahead of time. To reach another page, software first loads the latch and then branches. A small circular return stack keeps the resume addresses for calls and interrupts.

The surrounding core decodes instructions and raises at most the requests it needs. When several requests arrive in the same cycle, this unit resolves them by a fixed priority.

Top module: `paged_pc_unit`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and on the first cycle after it is released, the fetch address is 0x0000 and the page latch holds zero.
- R2: An advance request with no higher-priority request moves the fetch address to the current address plus one on the next clock, and 0x1FFF wraps to 0x0000.
- R3: A branch request loads its 11-bit target into address bits 10:0 and latch bits 4:3 into address bits 12:11.
- R4: A low-byte write makes the next address equal to latch bits 4:0 as bits 12:8 and the written byte as bits 7:0.
- R5: A call (a branch with the call flag set) pushes the current address plus one. A return pops the most recent 13-bit entry into the fetch address and leaves the page latch unchanged.
- R6: An interrupt request pushes the current address plus one and moves the fetch address to 0x0004.
- R7: The return stack holds 8 entries and is circular. A ninth push without a pop overwrites the oldest entry, and the following eight returns deliver the eight most recent pushes, newest first.
- R8: The page latch changes only on a latch write. A branch or low-byte write issued in the same cycle as a latch write uses the latch value from before that write.
- R9: Simultaneous requests are served in the order interrupt, branch, low-byte write, return, advance. Only the winner affects the address and the stack.
- R10: With no request asserted, the fetch address holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_req | input | 1 | Sequential advance request |
| br_req | input | 1 | Absolute branch request |
| br_call | input | 1 | With br_req: branch is a call and pushes a return address |
| br_target | input | 11 | In-page branch target |
| lo_wr | input | 1 | Write of the low program counter byte |
| lo_data | input | 8 | Byte written on lo_wr |
| ret_req | input | 1 | Return request (pop) |
| irq_req | input | 1 | Interrupt entry request |
| latch_wr | input | 1 | Page latch write enable |
| latch_data | input | 5 | Value written into the page latch |
| fetch_addr | output | 13 | Current fetch address |

## Verification
Plain advance is run both mid-space and across 0x1FFF, which separates a correct 13-bit wrap from a carry into the page bits. Jumps and calls are issued after loading page latches with distinct bit patterns, and one branch shares its cycle with a latch write, which shows whether the page comes from latch bits 4:3 and from the old latch value. Calls are nested nine deep and then unwound, which tells a circular stack from a saturating or truncating one. Stacks of competing requests, each shrinking by one winner at a time, pin down the priority order. A reset in the middle of the run confirms that both the address and the latch are cleared.

// File: rtl/paged_pc_pkg.sv
package paged_pc_pkg;

   typedef enum logic [2:0] {
      OP_HOLD = 3'd0,
      OP_ADV  = 3'd1,
      OP_RET  = 3'd2,
      OP_LOWR = 3'd3,
      OP_JUMP = 3'd4,
      OP_CALL = 3'd5,
      OP_IRQ  = 3'd6
   } pc_op_e;

endpackage

// File: rtl/pc_req_arbiter.sv
module pc_req_arbiter
   import paged_pc_pkg::*;
(
   input  logic   irq_req,
   input  logic   br_req,
   input  logic   br_call,
   input  logic   lo_wr,
   input  logic   ret_req,
   input  logic   adv_req,
   output pc_op_e op,
   output logic   push,
   output logic   pop
);

   always_comb begin
      if (irq_req)                op = OP_IRQ;
      else if (br_req && br_call) op = OP_CALL;
      else if (br_req)            op = OP_JUMP;
      else if (lo_wr)             op = OP_LOWR;
      else if (ret_req)           op = OP_RET;
      else if (adv_req)           op = OP_ADV;
      else                        op = OP_HOLD;
   end

   assign push = (op == OP_IRQ) || (op == OP_CALL);
   assign pop  = (op == OP_RET);

   always_comb begin
      a_push_pop_excl_r9: assert ($onehot0({push, pop}));
   end

endmodule

// File: rtl/pc_page_latch.sv
module pc_page_latch #(
   parameter int LATCH_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [LATCH_W-1:0] wr_data,
   output logic [LATCH_W-1:0] q
);

   generate
      if (LATCH_W < 1) begin : g_bad_width
         $error("pc_page_latch: LATCH_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wr_data;
   end

   p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));

   p_latch_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> q == $past(wr_data));

endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] push_data,
   output logic [DATA_W-1:0] top_data
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pc_ret_stack: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] slot [DEPTH];
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     top_ptr;

   assign top_ptr  = wr_ptr - 1'b1;
   assign top_data = slot[top_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
      end else if (push) begin
         wr_ptr <= wr_ptr + 1'b1;
      end else if (pop) begin
         wr_ptr <= top_ptr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      end else if (push) begin
         slot[wr_ptr] <= push_data;
      end
   end

   p_push_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> top_data == $past(push_data));

   p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> wr_ptr == AW'($past(wr_ptr) + 1'b1));

endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
   import paged_pc_pkg::*;
#(
   parameter int          PC_W        = 13,
   parameter int          OFS_W       = 11,
   parameter int          LO_W        = 8,
   parameter int          STACK_DEPTH = 8,
   parameter logic [12:0] IRQ_VECTOR  = 13'h0004
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv_req,
   input  logic                    br_req,
   input  logic                    br_call,
   input  logic [OFS_W-1:0]        br_target,
   input  logic                    lo_wr,
   input  logic [LO_W-1:0]         lo_data,
   input  logic                    ret_req,
   input  logic                    irq_req,
   input  logic                    latch_wr,
   input  logic [PC_W-LO_W-1:0]    latch_data,
   output logic [PC_W-1:0]         fetch_addr
);

   localparam int LATCH_W = PC_W - LO_W;
   localparam int PAGE_W  = PC_W - OFS_W;

   generate
      if (PAGE_W < 1 || PAGE_W > LATCH_W) begin : g_bad_page
         $error("paged_pc_unit: page field must fit inside the latch");
      end
      if (PC_W > 13) begin : g_bad_pc
         $error("paged_pc_unit: IRQ_VECTOR sized for at most 13 bits");
      end
   endgenerate

   pc_op_e            op;
   logic              push, pop;
   logic [LATCH_W-1:0] latch_q;
   logic [PC_W-1:0]   stack_top;
   logic [PC_W-1:0]   seq_addr;
   logic [PC_W-1:0]   nxt_addr;

   pc_req_arbiter u_arb (
      .irq_req (irq_req),
      .br_req  (br_req),
      .br_call (br_call),
      .lo_wr   (lo_wr),
      .ret_req (ret_req),
      .adv_req (adv_req),
      .op      (op),
      .push    (push),
      .pop     (pop)
   );

   pc_page_latch #(.LATCH_W(LATCH_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (latch_wr),
      .wr_data (latch_data),
      .q       (latch_q)
   );

   assign seq_addr = fetch_addr + 1'b1;

   pc_ret_stack #(.DEPTH(STACK_DEPTH), .DATA_W(PC_W)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .push_data (seq_addr),
      .top_data  (stack_top)
   );

   always_comb begin
      unique case (op)
         OP_IRQ:           nxt_addr = IRQ_VECTOR[PC_W-1:0];
         OP_CALL, OP_JUMP: nxt_addr = {latch_q[LATCH_W-1 -: PAGE_W], br_target};
         OP_LOWR:          nxt_addr = {latch_q, lo_data};
         OP_RET:           nxt_addr = stack_top;
         OP_ADV:           nxt_addr = seq_addr;
         default:          nxt_addr = fetch_addr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fetch_addr <= '0;
      else        fetch_addr <= nxt_addr;
   end

   p_adv_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_req && !irq_req && !br_req && !lo_wr && !ret_req)
      |=> fetch_addr == PC_W'($past(fetch_addr) + 1'b1));

   p_branch_ofs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (br_req && !irq_req) |=> fetch_addr[OFS_W-1:0] == $past(br_target));

   p_lowr_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr && !irq_req && !br_req) |=> fetch_addr[LO_W-1:0] == $past(lo_data));

   p_ret_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && !irq_req && !br_req && !lo_wr) |=> fetch_addr == $past(stack_top));

   p_irq_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> fetch_addr == IRQ_VECTOR[PC_W-1:0]);

   p_irq_saves_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> stack_top == PC_W'($past(fetch_addr) + 1'b1));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_req && !irq_req && !br_req && !lo_wr && !ret_req) |=> $stable(fetch_addr));

endmodule

// File: tb/paged_pc_unit_bench.sv
module paged_pc_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adv_req = 0, br_req = 0, br_call = 0, lo_wr = 0, ret_req = 0, irq_req = 0, latch_wr = 0;
   logic [10:0] br_target = '0;
   logic [7:0]  lo_data = '0;
   logic [4:0]  latch_data = '0;
   logic [12:0] fetch_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [12:0] exp_pc = '0;
   logic [4:0]  exp_latch = '0;
   logic [12:0] stk[$];

   always #10 clk = ~clk;

   paged_pc_unit u_paged_pc_unit (
      .clk(clk), .rst_n(rst_n), .adv_req(adv_req), .br_req(br_req), .br_call(br_call),
      .br_target(br_target), .lo_wr(lo_wr), .lo_data(lo_data), .ret_req(ret_req),
      .irq_req(irq_req), .latch_wr(latch_wr), .latch_data(latch_data),
      .fetch_addr(fetch_addr)
   );

   task automatic check(input string tag);
      checks++;
      if (fetch_addr !== exp_pc) begin
         fails++;
         $display("FAIL %s: fetch_addr actual %h expected %h", tag, fetch_addr, exp_pc);
      end
   endtask

   task automatic push_model(input logic [12:0] v);
      stk.push_back(v);
      if (stk.size() > 8) stk.delete(0);
   endtask

   task automatic clear_inputs();
      adv_req = 0; br_req = 0; br_call = 0; lo_wr = 0; ret_req = 0; irq_req = 0; latch_wr = 0;
   endtask

   // one clock: inputs already driven; model follows the requirement text
   task automatic step(input string tag);
      logic [12:0] nxt;
      @(posedge clk);
      nxt = exp_pc;
      if (irq_req) begin
         push_model(exp_pc + 13'd1);
         nxt = 13'h0004;
      end else if (br_req) begin
         if (br_call) push_model(exp_pc + 13'd1);
         nxt = {exp_latch[4:3], br_target};
      end else if (lo_wr) begin
         nxt = {exp_latch, lo_data};
      end else if (ret_req) begin
         if (stk.size() > 0) nxt = stk.pop_back();
      end else if (adv_req) begin
         nxt = exp_pc + 13'd1;
      end
      exp_pc = nxt;
      if (latch_wr) exp_latch = latch_data;
      @(negedge clk);
      check(tag);
      clear_inputs();
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      check("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release");

      // R2 advance
      for (int i = 0; i < 3; i++) begin adv_req = 1; step("R2 advance"); end
      // R10 idle
      for (int i = 0; i < 2; i++) step("R10 idle hold");

      // R8 latch write alongside advance, page bits 10
      latch_data = 5'b10110; latch_wr = 1; adv_req = 1; step("R8 latch write");
      // R3 jump into page 2
      br_req = 1; br_target = 11'h123; step("R3 jump page");
      // R8 call in same cycle as latch write uses old latch
      br_req = 1; br_call = 1; br_target = 11'h055;
      latch_wr = 1; latch_data = 5'b01000; step("R8 old latch on branch");
      // R5 nested call with new latch (page 1)
      br_req = 1; br_call = 1; br_target = 11'h200; step("R5 call");
      ret_req = 1; step("R5 return inner");
      ret_req = 1; step("R5 return outer");
      // R4 low-byte write; also shows return left latch alone (R5)
      lo_wr = 1; lo_data = 8'h9A; step("R4 low byte write");

      // R9 interrupt beats everything, R6 vector
      irq_req = 1; br_req = 1; lo_wr = 1; lo_data = 8'h11; ret_req = 1; adv_req = 1;
      step("R6 R9 interrupt wins");
      br_req = 1; br_target = 11'h7FF; lo_wr = 1; lo_data = 8'h22; ret_req = 1; adv_req = 1;
      step("R9 branch over lower");
      lo_wr = 1; lo_data = 8'h44; ret_req = 1; adv_req = 1;
      step("R9 low write over return");
      ret_req = 1; adv_req = 1;
      step("R9 return over advance");

      // R7 nine nested calls, eight returns
      for (int i = 0; i < 9; i++) begin
         br_req = 1; br_call = 1; br_target = 11'(i * 8 + 3); step("R7 deep call");
      end
      for (int i = 0; i < 8; i++) begin ret_req = 1; step("R7 unwind"); end

      // R2 wrap at top of space
      latch_wr = 1; latch_data = 5'h1F; step("R8 latch to top");
      lo_wr = 1; lo_data = 8'hFF; step("R4 top address");
      adv_req = 1; step("R2 wrap to zero");
      adv_req = 1; step("R2 after wrap");

      // R1 reset mid run clears address and latch
      @(negedge clk);
      rst_n = 1'b0;
      exp_pc = '0; exp_latch = '0; stk.delete();
      #1 check("R1 async reset");
      @(negedge clk);
      rst_n = 1'b1;
      lo_wr = 1; lo_data = 8'h33; step("R1 latch cleared");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule